// File: doc/BRIEF.md
# Privilege Mode and Storage Key Guard

This unit sits between the microsequencer, the control store and the gate drivers of a microprogrammed processor. It holds a single privilege bit that selects supervisor or user operation. While user code runs, a fixed set of gating bits are treated as privileged and are forced inactive before they reach the datapath. Protection is therefore applied bit by bit, not to whole operations. The only way into supervisor operation is a micro-branch that lands on one fixed entry address. A dedicated control bit leaves supervisor operation.

Control memory is split into equal blocks. Each block has a storage key and a read-protect enable. Every control-memory write is compared with the key of the running program. Every read is compared as well when that block has read protection enabled. A denied access is blocked in the same cycle and sets a sticky violation flag. The memory array and the trap sequence that follows a violation are outside this unit.

Top module: `privGuard`

## Requirements
- R1: After reset the unit is in supervisor mode (`supMode`=1), `violation` is 0, every block key and the program key are 0 and read protection is off, so any write is granted.
- R2: In user mode (`supMode`=0), `gateOut` equals `gateIn` with every bit set in `PRIV_MASK` (default 16'hF00F) forced to 0. In supervisor mode, `gateOut` equals `gateIn`. Both are combinational.
- R3: `supMode` becomes 1 on the clock edge where `branchValid` is high and `branchTarget` equals `ENTRY_ADDR` (default 12'h0F0). A branch to any other target leaves the mode unchanged.
- R4: `retToUser` sampled high in supervisor mode clears `supMode` at that edge. When an entry branch happens in the same cycle, the entry branch wins and the mode stays supervisor.
- R5: A write is granted (`wrGrant`=1, combinational) when the program key is 0 (the master key) or when it equals the key of the addressed block. Otherwise `wrGrant` is 0, and `violation` is 1 after the next edge.
- R6: A read of a block without read protection is always granted. A read of a read-protected block with a mismatched key has `rdGrant`=0 and `rdDataOut`=0, and sets `violation` at the next edge. A granted read passes `rdDataIn` to `rdDataOut`.
- R7: In supervisor mode, `keyWr` updates state at the edge: the program key to `keyData` when `keyIsProg`=1, or otherwise block `keyBlk`'s key to `keyData` and its read-protect enable to `keyRdProt`. In user mode the write is ignored and sets `violation`.
- R8: `violation` stays 1 until `clearViol` is sampled high in supervisor mode. In user mode `clearViol` has no effect. A new violation in the same cycle as a clear keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| branchValid | input | 1 | A micro-branch is taken this cycle |
| branchTarget | input | 12 | Target micro-address of the branch |
| retToUser | input | 1 | Request to leave supervisor mode |
| gateIn | input | 16 | Gating word from the microinstruction |
| gateOut | output | 16 | Gating word after privilege masking |
| memBlk | input | 4 | Block number (upper control-memory address bits) |
| memRd | input | 1 | Control-memory read strobe |
| memWr | input | 1 | Control-memory write strobe |
| rdDataIn | input | 16 | Data read from the control-memory array |
| rdDataOut | output | 16 | Read data, zero when the read is denied |
| wrGrant | output | 1 | Write enable passed to the array |
| rdGrant | output | 1 | Read permitted |
| keyWr | input | 1 | Key register write request |
| keyIsProg | input | 1 | 1 selects the program key, 0 selects a block key |
| keyBlk | input | 4 | Block whose key is written |
| keyData | input | 4 | New key value |
| keyRdProt | input | 1 | New read-protect enable for the block |
| clearViol | input | 1 | Clear the violation flag |
| supMode | output | 1 | 1 = supervisor, 0 = user |
| violation | output | 1 | Sticky protection violation flag |

## Verification
Masking, grants and read data are combinational, so they are sampled in the same cycle, one nanosecond after inputs change. Mode, key and flag updates appear one edge after the strobe. The bench drives each strobe just after a rising edge, steps one edge and samples just after it. Tests of ignored key writes check the effect through later write grants, not through internal state.

// File: rtl/privGuardPkg.sv
package privGuardPkg;
  typedef struct packed {
    logic supMode;
    logic keyLoad;
  } guardStrobe_t;
endpackage

// File: rtl/privCtrl.sv
module privCtrl
  import privGuardPkg::*;
#(
  parameter int UADDR_W = 12,
  parameter logic [UADDR_W-1:0] ENTRY_ADDR = 12'h0F0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               branchValid,
  input  logic [UADDR_W-1:0] branchTarget,
  input  logic               retToUser,
  input  logic               keyWr,
  input  logic               clearViol,
  input  logic               accDenied,
  output guardStrobe_t       strb,
  output logic               supMode,
  output logic               violation
);
  logic enterSup, leaveSup, setViol, clrViol;

  assign enterSup = branchValid && (branchTarget == ENTRY_ADDR);
  assign leaveSup = retToUser && supMode;
  assign setViol  = accDenied || (keyWr && !supMode);
  assign clrViol  = clearViol && supMode;

  assign strb.supMode = supMode;
  assign strb.keyLoad = keyWr && supMode;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supMode   <= 1'b1;
      violation <= 1'b0;
    end else begin
      if (enterSup)      supMode <= 1'b1;
      else if (leaveSup) supMode <= 1'b0;
      if (setViol)       violation <= 1'b1;
      else if (clrViol)  violation <= 1'b0;
    end
  end

  assert_entry_sets_mode_R3: assert property (@(posedge clk) disable iff (!rstN)
    (branchValid && branchTarget == ENTRY_ADDR) |=> supMode);
  assert_mode_only_via_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(supMode) |-> $past(branchValid && branchTarget == ENTRY_ADDR));
  assert_denied_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    accDenied |=> violation);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (violation && !(clearViol && supMode)) |=> violation);
endmodule

// File: rtl/privDatapath.sv
module privDatapath
  import privGuardPkg::*;
#(
  parameter int GATE_W = 16,
  parameter logic [GATE_W-1:0] PRIV_MASK = 16'hF00F,
  parameter int IDX_W  = 4,
  parameter int KEY_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      strb,
  input  logic [GATE_W-1:0] gateIn,
  output logic [GATE_W-1:0] gateOut,
  input  logic [IDX_W-1:0]  memBlk,
  input  logic              memRd,
  input  logic              memWr,
  input  logic [DATA_W-1:0] rdDataIn,
  output logic [DATA_W-1:0] rdDataOut,
  output logic              wrGrant,
  output logic              rdGrant,
  input  logic              keyIsProg,
  input  logic [IDX_W-1:0]  keyBlk,
  input  logic [KEY_W-1:0]  keyData,
  input  logic              keyRdProt,
  output logic              accDenied
);
  localparam int NBLK = 1 << IDX_W;

  logic [KEY_W-1:0] blkKey [NBLK];
  logic [NBLK-1:0]  rdProt;
  logic [KEY_W-1:0] progKey;
  logic             keyMatch, rdOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NBLK; i++) blkKey[i] <= '0;
      rdProt  <= '0;
      progKey <= '0;
    end else if (strb.keyLoad) begin
      if (keyIsProg) progKey <= keyData;
      else begin
        blkKey[keyBlk] <= keyData;
        rdProt[keyBlk] <= keyRdProt;
      end
    end
  end

  assign gateOut   = strb.supMode ? gateIn : (gateIn & ~PRIV_MASK);
  assign keyMatch  = (progKey == '0) || (blkKey[memBlk] == progKey);
  assign rdOk      = keyMatch || !rdProt[memBlk];
  assign wrGrant   = memWr && keyMatch;
  assign rdGrant   = memRd && rdOk;
  assign rdDataOut = rdGrant ? rdDataIn : '0;
  assign accDenied = (memWr && !keyMatch) || (memRd && !rdOk);

  assert_user_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.supMode |-> ((gateOut & PRIV_MASK) == '0));
  assert_user_no_keyload_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.supMode |-> !strb.keyLoad);
  assert_denied_read_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && !rdGrant) |-> (rdDataOut == '0));
endmodule

// File: rtl/privGuard.sv
module privGuard
  import privGuardPkg::*;
#(
  parameter int UADDR_W = 12,
  parameter logic [UADDR_W-1:0] ENTRY_ADDR = 12'h0F0,
  parameter int GATE_W = 16,
  parameter logic [GATE_W-1:0] PRIV_MASK = 16'hF00F,
  parameter int ADDR_W = 10,
  parameter int BLK_W  = 6,
  parameter int KEY_W  = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = ADDR_W - BLK_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               branchValid,
  input  logic [UADDR_W-1:0] branchTarget,
  input  logic               retToUser,
  input  logic [GATE_W-1:0]  gateIn,
  output logic [GATE_W-1:0]  gateOut,
  input  logic [IDX_W-1:0]   memBlk,
  input  logic               memRd,
  input  logic               memWr,
  input  logic [DATA_W-1:0]  rdDataIn,
  output logic [DATA_W-1:0]  rdDataOut,
  output logic               wrGrant,
  output logic               rdGrant,
  input  logic               keyWr,
  input  logic               keyIsProg,
  input  logic [IDX_W-1:0]   keyBlk,
  input  logic [KEY_W-1:0]   keyData,
  input  logic               keyRdProt,
  input  logic               clearViol,
  output logic               supMode,
  output logic               violation
);
  guardStrobe_t strb;
  logic         accDenied;

  privCtrl #(.UADDR_W(UADDR_W), .ENTRY_ADDR(ENTRY_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .branchValid(branchValid), .branchTarget(branchTarget),
    .retToUser(retToUser), .keyWr(keyWr), .clearViol(clearViol),
    .accDenied(accDenied), .strb(strb), .supMode(supMode), .violation(violation)
  );

  privDatapath #(.GATE_W(GATE_W), .PRIV_MASK(PRIV_MASK), .IDX_W(IDX_W),
                 .KEY_W(KEY_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .gateIn(gateIn), .gateOut(gateOut),
    .memBlk(memBlk), .memRd(memRd), .memWr(memWr), .rdDataIn(rdDataIn),
    .rdDataOut(rdDataOut), .wrGrant(wrGrant), .rdGrant(rdGrant),
    .keyIsProg(keyIsProg), .keyBlk(keyBlk), .keyData(keyData),
    .keyRdProt(keyRdProt), .accDenied(accDenied)
  );
endmodule

// File: tb/privGuard_bench.sv
module privGuard_bench;
  localparam logic [15:0] MASK  = 16'hF00F;
  localparam logic [11:0] ENTRY = 12'h0F0;
  localparam logic [15:0] GATE_VEC [8] = '{16'h0000, 16'hFFFF, 16'hF00F, 16'h0FF0,
                                          16'hA5A5, 16'h5A5A, 16'h8001, 16'h1234};

  logic clk = 0, rstN = 0;
  logic branchValid = 0, retToUser = 0, memRd = 0, memWr = 0;
  logic keyWr = 0, keyIsProg = 0, keyRdProt = 0, clearViol = 0;
  logic [11:0] branchTarget = 0;
  logic [15:0] gateIn = 0, rdDataIn = 0;
  logic [3:0]  memBlk = 0, keyBlk = 0, keyData = 0;
  logic [15:0] gateOut, rdDataOut;
  logic wrGrant, rdGrant, supMode, violation;
  int nVec = 0, nBad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  privGuard u_privGuard (
    .clk(clk), .rstN(rstN), .branchValid(branchValid), .branchTarget(branchTarget),
    .retToUser(retToUser), .gateIn(gateIn), .gateOut(gateOut), .memBlk(memBlk),
    .memRd(memRd), .memWr(memWr), .rdDataIn(rdDataIn), .rdDataOut(rdDataOut),
    .wrGrant(wrGrant), .rdGrant(rdGrant), .keyWr(keyWr), .keyIsProg(keyIsProg),
    .keyBlk(keyBlk), .keyData(keyData), .keyRdProt(keyRdProt),
    .clearViol(clearViol), .supMode(supMode), .violation(violation)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    branchValid = 0; retToUser = 0; memRd = 0; memWr = 0;
    keyWr = 0; clearViol = 0; keyIsProg = 0; keyRdProt = 0;
  endtask

  task automatic step();
    @(posedge clk); #1; idle();
  endtask

  task automatic keySet(bit isProg, logic [3:0] blk, logic [3:0] k, bit rp);
    keyWr = 1; keyIsProg = isProg; keyBlk = blk; keyData = k; keyRdProt = rp;
    step();
  endtask

  task automatic tryWrite(string req, logic [3:0] blk, bit exp);
    memWr = 1; memBlk = blk; #1;
    check(req, {31'd0, wrGrant}, {31'd0, exp});
    step();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nBad++; nVec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset state
    check("R1 supMode", {31'd0, supMode}, 1);
    check("R1 violation", {31'd0, violation}, 0);
    tryWrite("R1 write after reset", 4'd9, 1);
    check("R1 no violation", {31'd0, violation}, 0);

    // R2 supervisor passes every bit
    foreach (GATE_VEC[i]) begin
      gateIn = GATE_VEC[i]; #1;
      check("R2 sup gate", {16'd0, gateOut}, {16'd0, GATE_VEC[i]});
    end

    // R7 key programming in supervisor
    keySet(0, 4'd3, 4'd5, 1);
    keySet(0, 4'd4, 4'd7, 0);
    keySet(0, 4'd6, 4'd9, 1);
    keySet(1, 4'd0, 4'd5, 0);
    tryWrite("R5 matching block", 4'd3, 1);
    tryWrite("R7 R5 mismatching block", 4'd4, 0);
    check("R5 violation set", {31'd0, violation}, 1);
    clearViol = 1; step();
    check("R8 sup clear", {31'd0, violation}, 0);

    // R6 reads
    memRd = 1; memBlk = 4'd4; rdDataIn = 16'hBEEF; #1;
    check("R6 unprotected grant", {31'd0, rdGrant}, 1);
    check("R6 unprotected data", {16'd0, rdDataOut}, 32'hBEEF);
    step();
    memRd = 1; memBlk = 4'd3; rdDataIn = 16'hC0DE; #1;
    check("R6 protected match", {16'd0, rdDataOut}, 32'hC0DE);
    step();
    check("R6 no violation", {31'd0, violation}, 0);

    // R4 leave supervisor
    retToUser = 1; step();
    check("R4 user mode", {31'd0, supMode}, 0);
    foreach (GATE_VEC[i]) begin
      gateIn = GATE_VEC[i]; #1;
      check("R2 user gate", {16'd0, gateOut}, {16'd0, GATE_VEC[i] & ~MASK});
    end

    // R6 denied read
    memRd = 1; memBlk = 4'd6; rdDataIn = 16'hFFFF; #1;
    check("R6 denied grant", {31'd0, rdGrant}, 0);
    check("R6 denied data", {16'd0, rdDataOut}, 0);
    step();
    check("R6 violation", {31'd0, violation}, 1);
    clearViol = 1; step();
    check("R8 user clear ignored", {31'd0, violation}, 1);

    // R7 user key writes ignored
    keySet(1, 4'd0, 4'd0, 0);
    tryWrite("R7 prog key unchanged", 4'd4, 0);
    keySet(0, 4'd3, 4'd2, 0);
    tryWrite("R7 block key unchanged", 4'd3, 1);
    check("R7 user mode kept", {31'd0, supMode}, 0);

    // R3 entry
    branchValid = 1; branchTarget = ENTRY + 12'd1; step();
    check("R3 wrong target", {31'd0, supMode}, 0);
    branchValid = 1; branchTarget = ENTRY; step();
    check("R3 entry", {31'd0, supMode}, 1);
    gateIn = 16'hFFFF; #1;
    check("R2 sup again", {16'd0, gateOut}, 32'hFFFF);

    // R4 entry wins over retToUser
    branchValid = 1; branchTarget = ENTRY; retToUser = 1; step();
    check("R4 entry priority", {31'd0, supMode}, 1);

    // R8 set beats clear
    memWr = 1; memBlk = 4'd4; clearViol = 1; step();
    check("R8 set over clear", {31'd0, violation}, 1);
    clearViol = 1; step();
    check("R8 cleared", {31'd0, violation}, 0);

    // R5 master key
    keySet(1, 4'd0, 4'd0, 0);
    tryWrite("R5 master key", 4'd4, 1);
    tryWrite("R5 master key protected blk", 4'd6, 1);
    check("R5 no violation", {31'd0, violation}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule